// File: doc/BRIEF.md
# Instruction Cycle Pairing Accumulator

This unit does the cycle bookkeeping for a timing model of a 16/32-bit processor. It receives one record for each retired instruction. A record holds the raw cycle cost, a 6-bit opcode family index and the bus penalty caused by indexed-with-displacement addressing. The unit normally rounds each cost up to the 4-cycle bus granularity. Two adjacent instructions can each end half-way through a bus slot. If a programmable family-pair table allows the two families to pair, the unit drops the rounding, and the pair then costs 4 cycles less than it would when charged separately. A penalty of 4 with a cost that is a multiple of 4 can also pair. In that case the cost is charged as it is.

The adjusted charge is shifted right by a frequency-shift amount. It is then presented on an output stream, added to a running main cycle counter and subtracted from a down-counting interrupt budget. Instruction records enter on a valid/ready stream. Results leave through a single output register with valid/ready. The input is accepted when `in_ready` is high, which is whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its values and no new instruction is accepted. Counters and pairing history change only in the cycle an instruction is accepted.

Top module: `cycle_pair_acc`

## Requirements
- R1: An unpaired instruction is charged (cycles + penalty) rounded up to the next multiple of 4, i.e. (cycles + penalty + 3) with bits [1:0] cleared.
- R2: Pairing is flagged only when all three hold: the table bit at (stored family, current family) is 1; the stored cost has bits [1:0] == 2'b10; and either the current cycles have bits [1:0] == 2'b10 or the penalty is non-zero.
- R3: A paired instruction whose cycles have bits [1:0] == 2'b10 is charged cycles - 2, with no rounding and no penalty added.
- R4: A paired instruction whose cycles are not of the form 4n+2 (the double indexed move with penalty 4) is charged its cycles unchanged.
- R5: Every accepted instruction stores its family and the unrounded sum cycles + penalty as the history for the next decision. This includes instructions accepted in plain mode. The penalty affects only the instruction it arrives with.
- R6: The charge on `out_charge` and the amount accumulated are the adjusted charge shifted right by `freq_shift`.
- R7: On each acceptance `main_count` increases by the shifted charge and `irq_budget` decreases by the same amount (modulo 2^CNT_W). Both counters reset to 0.
- R8: After reset the stored cost is 0 and the stored family is 0, so the first instruction never pairs, even when table bit (0, family) is 1.
- R9: While `plain_mode` is 1, no pairing is flagged and every charge follows R1.
- R10: `in_ready` = !out_valid || out_ready. While out_valid && !out_ready, `out_charge`, `out_paired` and both counters hold.
- R11: A cycle with `tbl_we` = 1 writes `tbl_bit` into the table at (`tbl_prev`, `tbl_cur`). A 0 bit prevents pairing of that family order. The table resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plain_mode | input | 1 | 1 = round every instruction, never pair |
| freq_shift | input | SHIFT_W (2) | Right shift applied to each charge |
| tbl_we | input | 1 | Pair-table write enable |
| tbl_prev | input | FAM_W (6) | Table row: earlier family |
| tbl_cur | input | FAM_W (6) | Table column: later family |
| tbl_bit | input | 1 | Value written to the table |
| in_valid | input | 1 | Instruction record valid |
| in_ready | output | 1 | Record accepted this cycle when high with in_valid |
| in_cycles | input | CYC_W (8) | Raw instruction cycle cost |
| in_family | input | FAM_W (6) | Opcode family index |
| in_penalty | input | PEN_W (3) | Indexed-addressing bus penalty (0, 2 or 4) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_paired | output | 1 | Instruction paired with its predecessor |
| out_charge | output | CYC_W+1 (9) | Shifted charge for the instruction |
| main_count | output | CNT_W (32) | Running main cycle counter |
| irq_budget | output | CNT_W (32) | Down-counting interrupt budget |

## Verification
Assertions check four things on every cycle. Main count and budget always sum to zero. Each acceptance moves the main count by exactly the presented charge. Plain mode never yields a pairing flag. A stalled output holds steady. Unpaired charges are also checked to be multiples of 4 before the shift, and table writes are checked to land. Only the bench scenarios can show the pairing decisions themselves, because they depend on stored history and table contents. These decisions are: the three-way pairing condition, the trim and keep charges, the penalty carried into the next decision, the reset history that blocks a first pairing, and history updates during plain mode.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  // How a charge was formed.
  typedef enum logic [1:0] {
    CK_ROUND = 2'd0,  // unpaired: cost plus penalty, rounded up to 4
    CK_TRIM  = 2'd1,  // paired 4n+2: drop the half slot
    CK_KEEP  = 2'd2   // paired with penalty on a 4n cost: charge as is
  } charge_kind_e;
endpackage

// File: rtl/cpa_pair_table.sv
module cpa_pair_table #(
  parameter int FAM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FAM_W-1:0] wr_prev,
  input  logic [FAM_W-1:0] wr_cur,
  input  logic             wr_bit,
  input  logic [FAM_W-1:0] rd_prev,
  input  logic [FAM_W-1:0] rd_cur,
  output logic             rd_bit
);
  localparam int NFAM = 1 << FAM_W;

  logic [NFAM-1:0] row_q [NFAM];

  for (genvar r = 0; r < NFAM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) row_q[r] <= '0;
      else if (we && (wr_prev == FAM_W'(r))) row_q[r][wr_cur] <= wr_bit;
    end
  end

  assign rd_bit = row_q[rd_prev][rd_cur];

  assert_table_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (row_q[$past(wr_prev)][$past(wr_cur)] == $past(wr_bit)));
endmodule

// File: rtl/cpa_charge_calc.sv
module cpa_charge_calc
  import cpa_pkg::*;
#(
  parameter int CYC_W   = 8,
  parameter int PEN_W   = 3,
  parameter int SHIFT_W = 2,
  localparam int COST_W = CYC_W + 1
) (
  input  logic               allow,      // table bit and not plain mode
  input  logic [COST_W-1:0]  prev_cost,
  input  logic [CYC_W-1:0]   cycles,
  input  logic [PEN_W-1:0]   penalty,
  input  logic [SHIFT_W-1:0] shift,
  output logic               paired,
  output charge_kind_e       kind,
  output logic [COST_W-1:0]  cost_sum,
  output logic [COST_W-1:0]  charge_full,
  output logic [COST_W-1:0]  charge_shifted
);
  logic [COST_W-1:0] biased;
  logic              cur_half;
  logic              prev_half;

  always_comb begin
    cost_sum  = COST_W'(cycles) + COST_W'(penalty);
    biased    = cost_sum + COST_W'(3);
    cur_half  = (cycles[1:0] == 2'b10);
    prev_half = (prev_cost[1:0] == 2'b10);
    paired    = allow && prev_half && (cur_half || (penalty != '0));

    if (!paired)      kind = CK_ROUND;
    else if (cur_half) kind = CK_TRIM;
    else               kind = CK_KEEP;

    unique case (kind)
      CK_TRIM: charge_full = COST_W'(cycles) - COST_W'(2);
      CK_KEEP: charge_full = COST_W'(cycles);
      default: charge_full = {biased[COST_W-1:2], 2'b00};
    endcase

    charge_shifted = charge_full >> shift;
  end
endmodule

// File: rtl/cpa_counters.sv
module cpa_counters #(
  parameter int CNT_W = 32,
  parameter int AMT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [AMT_W-1:0] amount,
  output logic [CNT_W-1:0] main_count,
  output logic [CNT_W-1:0] irq_budget
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_count <= '0;
      irq_budget <= '0;
    end else if (add_en) begin
      main_count <= main_count + CNT_W'(amount);
      irq_budget <= irq_budget - CNT_W'(amount);
    end
  end

  assert_counts_balance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_count + irq_budget) == '0);
endmodule

// File: rtl/cycle_pair_acc.sv
module cycle_pair_acc
  import cpa_pkg::*;
#(
  parameter int FAM_W   = 6,
  parameter int CYC_W   = 8,
  parameter int PEN_W   = 3,
  parameter int SHIFT_W = 2,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               plain_mode,
  input  logic [SHIFT_W-1:0] freq_shift,
  input  logic               tbl_we,
  input  logic [FAM_W-1:0]   tbl_prev,
  input  logic [FAM_W-1:0]   tbl_cur,
  input  logic               tbl_bit,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CYC_W-1:0]   in_cycles,
  input  logic [FAM_W-1:0]   in_family,
  input  logic [PEN_W-1:0]   in_penalty,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_paired,
  output logic [CYC_W:0]     out_charge,
  output logic [CNT_W-1:0]   main_count,
  output logic [CNT_W-1:0]   irq_budget
);
  localparam int COST_W = CYC_W + 1;

  logic [FAM_W-1:0]  prev_fam_q;
  logic [COST_W-1:0] prev_cost_q;
  logic              tbl_hit;
  logic              fire;
  logic              calc_paired;
  charge_kind_e      calc_kind;
  logic [COST_W-1:0] calc_sum;
  logic [COST_W-1:0] calc_full;
  logic [COST_W-1:0] calc_shifted;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  cpa_pair_table #(.FAM_W(FAM_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .wr_prev (tbl_prev),
    .wr_cur  (tbl_cur),
    .wr_bit  (tbl_bit),
    .rd_prev (prev_fam_q),
    .rd_cur  (in_family),
    .rd_bit  (tbl_hit)
  );

  cpa_charge_calc #(.CYC_W(CYC_W), .PEN_W(PEN_W), .SHIFT_W(SHIFT_W)) u_calc (
    .allow          (tbl_hit && !plain_mode),
    .prev_cost      (prev_cost_q),
    .cycles         (in_cycles),
    .penalty        (in_penalty),
    .shift          (freq_shift),
    .paired         (calc_paired),
    .kind           (calc_kind),
    .cost_sum       (calc_sum),
    .charge_full    (calc_full),
    .charge_shifted (calc_shifted)
  );

  cpa_counters #(.CNT_W(CNT_W), .AMT_W(COST_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .add_en     (fire),
    .amount     (calc_shifted),
    .main_count (main_count),
    .irq_budget (irq_budget)
  );

  // Pairing history: raw cost plus penalty, not rounded.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_fam_q  <= '0;
      prev_cost_q <= '0;
    end else if (fire) begin
      prev_fam_q  <= in_family;
      prev_cost_q <= calc_sum;
    end
  end

  // Output register stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_paired <= 1'b0;
      out_charge <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_paired <= calc_paired;
      out_charge <= calc_shifted;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_plain_no_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && plain_mode) |=> !out_paired);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_charge) && $stable(out_paired)
                                   && $stable(main_count)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (main_count == $past(main_count) + CNT_W'(out_charge)));

  assert_round_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (calc_kind == CK_ROUND)) |-> (calc_full[1:0] == 2'b00));
endmodule

// File: tb/cycle_pair_acc_test.sv
module cycle_pair_acc_test;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plain_mode = 1'b0;
  logic [1:0]  freq_shift = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_prev = '0;
  logic [5:0]  tbl_cur = '0;
  logic        tbl_bit = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_cycles = '0;
  logic [5:0]  in_family = '0;
  logic [2:0]  in_penalty = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_paired;
  logic [8:0]  out_charge;
  logic [31:0] main_count;
  logic [31:0] irq_budget;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_main = '0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  cycle_pair_acc uut (
    .clk(clk), .rst_n(rst_n), .plain_mode(plain_mode), .freq_shift(freq_shift),
    .tbl_we(tbl_we), .tbl_prev(tbl_prev), .tbl_cur(tbl_cur), .tbl_bit(tbl_bit),
    .in_valid(in_valid), .in_ready(in_ready), .in_cycles(in_cycles),
    .in_family(in_family), .in_penalty(in_penalty), .out_valid(out_valid),
    .out_ready(out_ready), .out_paired(out_paired), .out_charge(out_charge),
    .main_count(main_count), .irq_budget(irq_budget)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tbl_write(int p, int c, bit b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_prev = 6'(p); tbl_cur = 6'(c); tbl_bit = b;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Send one instruction, then check flag, charge and both counters.
  task automatic send(string req, int cyc, int fam, int pen, bit exp_pair, int exp_chg);
    @(negedge clk);
    in_valid = 1'b1; in_cycles = 8'(cyc); in_family = 6'(fam); in_penalty = 3'(pen);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_main = exp_main + 32'(exp_chg);
    check(req, "out_valid", out_valid, 1);
    check(req, "out_paired", out_paired, exp_pair);
    check(req, "out_charge", out_charge, exp_chg);
    check("R7", "main_count", main_count, exp_main);
    check("R7", "irq_budget", irq_budget, 32'(32'd0 - exp_main));
  endtask

  task automatic t_reset();
    check("R7", "reset main_count", main_count, 0);
    check("R7", "reset irq_budget", irq_budget, 0);
    check("R10", "reset out_valid", out_valid, 0);
    check("R10", "reset in_ready", in_ready, 1);
  endtask

  task automatic t_setup_table();
    tbl_write(0, 1, 1);
    tbl_write(1, 2, 1);
    tbl_write(3, 4, 1);
    tbl_write(5, 5, 1);
  endtask

  task automatic t_first_and_pair();
    send("R8", 14, 1, 0, 0, 16);   // reset history blocks pairing
    send("R3", 14, 2, 2, 1, 12);   // 14+14 pair = 28 in total
    check("R2", "pair total", main_count, 28);
  endtask

  task automatic t_unpaired_penalty();
    send("R1", 20, 6, 2, 0, 24);
    send("R1", 10, 3, 0, 0, 12);
  endtask

  task automatic t_double_index();
    send("R4", 24, 4, 4, 1, 24);
  endtask

  task automatic t_table_bits();
    send("R11", 6, 5, 0, 0, 8);    // (4,5) never written
    send("R2", 6, 5, 0, 1, 4);     // (5,5) set, 6 and 6
    tbl_write(5, 5, 0);
    send("R11", 6, 5, 0, 0, 8);    // cleared bit blocks pairing
  endtask

  task automatic t_history_penalty();
    send("R5", 12, 1, 2, 0, 16);   // stored cost 14
    send("R5", 6, 2, 0, 1, 4);     // pairs only through the stored penalty
  endtask

  task automatic t_plain();
    plain_mode = 1'b1;
    send("R9", 14, 1, 0, 0, 16);
    send("R9", 14, 2, 2, 0, 16);   // would pair, plain mode rounds
    send("R9", 14, 1, 0, 0, 16);
    plain_mode = 1'b0;
    send("R5", 14, 2, 0, 1, 12);   // history kept during plain mode
  endtask

  task automatic t_shift();
    freq_shift = 2'd1;
    send("R6", 20, 6, 2, 0, 12);
    freq_shift = 2'd2;
    send("R6", 14, 1, 0, 0, 4);
    send("R6", 14, 2, 0, 1, 3);
    freq_shift = 2'd0;
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    send("R10", 8, 6, 0, 0, 8);
    held = main_count;
    @(negedge clk);
    in_valid = 1'b1; in_cycles = 8'd30; in_family = 6'd7; in_penalty = 3'd0;
    check("R10", "in_ready stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    check("R10", "charge held", out_charge, 8);
    check("R10", "counter held", main_count, held);
    check("R10", "valid held", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_main = exp_main + 32;
    check("R10", "stalled record charge", out_charge, 32);
    check("R7", "main after stall", main_count, exp_main);
    @(negedge clk);
    check("R10", "drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_table();
    t_first_and_pair();
    t_unpaired_penalty();
    t_double_index();
    t_table_bits();
    t_history_penalty();
    t_plain();
    t_shift();
    t_backpressure();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule